// File: doc/BRIEF.md
# Packed Lane Saturating and Halving Adder

This block is a one-stage arithmetic unit for packed data. It takes two 32-bit operands and an operation code, and splits each operand into four 8-bit lanes, two 16-bit lanes or one 32-bit lane. In every lane it adds or subtracts, treating the lanes as either signed or unsigned. It then gives either a clamped result or a result that is half the exact sum or difference.

Each lane is computed apart from the others. No carry or borrow crosses a lane edge. The result is registered and appears one clock after the valid strobe, together with a one-cycle done pulse. A per-lane sticky flag vector records every lane that had to be clamped. A clear input empties that vector.

Opcode fields:
- `op[1:0]` selects the lane size: 00 gives bytes, 01 gives halfwords, and 10 or 11 gives one word.
- `op[2]` selects subtract when it is 1.
- `op[3]` selects halving when it is 1.
- `op[4]` selects unsigned when it is 1.

Top module: `simd_sat_alu`

## Requirements
- R1: For a signed byte operation (op = 5'b0_0_x_00), each of the four byte lanes gives a+b or a-b clamped to the range -128..127.
- R2: For a signed halfword operation (op[1:0] = 01), each of the two 16-bit lanes gives the sum or difference clamped to the range -32768..32767.
- R3: For a signed word operation (op[1:0] = 10), the whole 32-bit sum or difference is clamped to the range -2^31..2^31-1.
- R4: When op[4] = 1 and op[3] = 0, lanes are unsigned and clamp to the range 0..2^w-1, where w is the lane width.
- R5: When op[3] = 1, each lane gives floor((a op b)/2). The sum or difference is formed one bit wider than the lane, so there is no overflow. Signed or unsigned follows op[4]. A halving operation never sets a flag.
- R6: In byte and halfword modes, a carry or borrow out of one lane never changes any other lane.
- R7: `result` and `done` update on the first rising edge at which `in_valid` is high. `done` is high for exactly the cycle after each accepted operation. `result` holds its value while `in_valid` is low.
- R8: `sat_flags` is sticky. Bit k is set when lane k of an accepted saturating operation is clamped. Byte lanes map to bits 0..3, halfword lanes to bits 0..1, and the word lane to bit 0. A flag stays set until it is cleared.
- R9: A high `clr_flags` zeroes `sat_flags` on the next edge. It takes priority over a flag set in the same cycle.
- R10: After reset, `result`, `sat_flags` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 5 | Operation code: size, subtract, halving, unsigned |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| clr_flags | input | 1 | Clears the sticky clamp flags |
| result | output | 32 | Registered packed result |
| sat_flags | output | 4 | Sticky per-lane clamp flags |
| done | output | 1 | Pulses one cycle after an accepted operation |

## Verification
Any fault in the lane arithmetic shows up on `result` one cycle after the strobe that caused it. Lane-boundary operands, such as 0x000000FF plus 1, catch a carry that leaks across lanes in that same cycle. A flag register that loses a bit, or sets one wrongly, stays wrong at the ports until `clr_flags` is used. Every operation therefore also compares the accumulated flag vector. Idle cycles between operations show a result register that moves without a strobe, or a done pulse that lasts too long.

// File: rtl/simd_sat_alu.sv
module simd_sat_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [4:0]  op,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic        clr_flags,
  output logic [31:0] result,
  output logic [3:0]  sat_flags,
  output logic        done
);

  wire is_sub  = op[2];
  wire is_half = op[3];
  wire is_uns  = op[4];

  function automatic logic [32:0] lane_fn(input logic [31:0] x, input logic [31:0] y,
                                          input int unsigned w, input logic sub,
                                          input logic half, input logic uns);
    logic [31:0] xl, yl, mask;
    logic signed [33:0] ex, ey, s, hi, lo, r;
    logic ov;
    xl = x << (32 - w);
    yl = y << (32 - w);
    if (uns) begin
      ex = $signed({2'b00, xl} >> (32 - w));
      ey = $signed({2'b00, yl} >> (32 - w));
    end else begin
      ex = $signed({xl[31], xl[31], xl}) >>> (32 - w);
      ey = $signed({yl[31], yl[31], yl}) >>> (32 - w);
    end
    s  = sub ? ex - ey : ex + ey;
    hi = uns ? (34'sd1 <<< w) - 34'sd1 : (34'sd1 <<< (w - 1)) - 34'sd1;
    lo = uns ? 34'sd0 : -(34'sd1 <<< (w - 1));
    ov = 1'b0;
    if (half)         r = s >>> 1;
    else if (s > hi) begin r = hi; ov = 1'b1; end
    else if (s < lo) begin r = lo; ov = 1'b1; end
    else              r = s;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return {ov, r[31:0] & mask};
  endfunction

  logic [31:0] nxt;
  logic [3:0]  lane_ov;
  logic [32:0] tmp;

  always_comb begin
    nxt     = '0;
    lane_ov = '0;
    tmp     = '0;
    case (op[1:0])
      2'b00: for (int k = 0; k < 4; k++) begin
        tmp = lane_fn(a >> (8 * k), b >> (8 * k), 8, is_sub, is_half, is_uns);
        nxt[8*k +: 8] = tmp[7:0];
        lane_ov[k]    = tmp[32];
      end
      2'b01: for (int k = 0; k < 2; k++) begin
        tmp = lane_fn(a >> (16 * k), b >> (16 * k), 16, is_sub, is_half, is_uns);
        nxt[16*k +: 16] = tmp[15:0];
        lane_ov[k]      = tmp[32];
      end
      default: begin
        tmp        = lane_fn(a, b, 32, is_sub, is_half, is_uns);
        nxt        = tmp[31:0];
        lane_ov[0] = tmp[32];
      end
    endcase
  end

  wire [3:0] set_bits = (in_valid && !is_half) ? lane_ov : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      sat_flags <= '0;
      done      <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) result <= nxt;
      sat_flags <= clr_flags ? 4'b0 : (sat_flags | set_bits);
    end
  end

endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [4:0]  op,
  input logic        clr_flags,
  input logic [31:0] result,
  input logic [3:0]  sat_flags,
  input logic        done
);

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R7
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_flags |=> ((sat_flags & $past(sat_flags)) == $past(sat_flags))); // R8
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags |=> (sat_flags == 4'b0)); // R9
  AST_HALF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[3] && !clr_flags) |=> $stable(sat_flags)); // R5
  AST_WORD_LANE0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[1] && !clr_flags) |=> (sat_flags[3:1] == $past(sat_flags[3:1]))); // R8
  AST_HALFWORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[1:0] == 2'b01 && !clr_flags) |=> (sat_flags[3:2] == $past(sat_flags[3:2]))); // R8

endmodule

bind simd_sat_alu simd_sat_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .clr_flags(clr_flags),
  .result(result), .sat_flags(sat_flags), .done(done)
);

// File: tb/sim_simd_sat_alu.sv
`timescale 1ns/1ps
module sim_simd_sat_alu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [4:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        clr_flags = 0;
  logic [31:0] result;
  logic [3:0]  sat_flags;
  logic        done;

  int tests = 0, fails = 0;
  logic [3:0] exp_flags = '0;
  logic [31:0] last_res = '0;

  always #10 clk = ~clk;

  simd_sat_alu u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
                   .clr_flags(clr_flags), .result(result), .sat_flags(sat_flags), .done(done));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_op(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                        output logic [31:0] r, output logic [3:0] f);
    int w, n;
    longint xv, yv, s, top, bot, m;
    w = (o[1:0] == 2'b00) ? 8 : (o[1:0] == 2'b01) ? 16 : 32;
    n = 32 / w;
    m = longint'(1) << w;
    r = '0; f = '0;
    for (int k = 0; k < n; k++) begin
      xv = longint'((x >> (k * w))) & (m - 1);
      yv = longint'((y >> (k * w))) & (m - 1);
      if (!o[4]) begin
        if (xv >= m / 2) xv = xv - m;
        if (yv >= m / 2) yv = yv - m;
      end
      s = o[2] ? xv - yv : xv + yv;
      if (o[3]) s = s >>> 1;
      else begin
        top = o[4] ? m - 1 : m / 2 - 1;
        bot = o[4] ? 0 : -(m / 2);
        if (s > top) begin s = top; f[k] = 1'b1; end
        if (s < bot) begin s = bot; f[k] = 1'b1; end
      end
      s = s & (m - 1);
      r = r | (32'(s) << (k * w));
    end
  endtask

  task automatic run_op(input string tag, input logic [4:0] o, input logic [31:0] x,
                        input logic [31:0] y, input logic clr);
    logic [31:0] er; logic [3:0] ef;
    ref_op(o, x, y, er, ef);
    @(negedge clk);
    in_valid = 1; op = o; a = x; b = y; clr_flags = clr;
    @(negedge clk);
    in_valid = 0; clr_flags = 0;
    exp_flags = clr ? 4'b0 : (exp_flags | (o[3] ? 4'b0 : ef));
    last_res = er;
    check({tag, " result"}, result, er);
    check({tag, " done R7"}, {31'b0, done}, 32'd1);
    check({tag, " flags R8"}, {28'b0, sat_flags}, {28'b0, exp_flags});
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R7 done drops", {31'b0, done}, 32'd0);
    a = 32'h1234_5678; b = 32'h7FFF_FFFF;
    @(negedge clk);
    check("R7 result held", result, last_res);
  endtask

  task automatic t_reset();
    check("R10 result", result, 32'd0);
    check("R10 flags", {28'b0, sat_flags}, 32'd0);
    check("R10 done", {31'b0, done}, 32'd0);
  endtask

  task automatic t_bytes();
    run_op("R1 byte add", 5'b00000, 32'h7F80_4010, 32'h01FF_4005, 0);
    run_op("R1 byte sub", 5'b00100, 32'h8010_7F00, 32'h0120_8101, 0);
  endtask

  task automatic t_halves();
    run_op("R2 half add", 5'b00001, 32'h7000_8000, 32'h2000_8000, 0);
    run_op("R2 half sub", 5'b00101, 32'h1234_7FFF, 32'h0034_8000, 0);
  endtask

  task automatic t_word();
    run_op("R3 word add", 5'b00010, 32'h7FFF_FFF0, 32'h0000_0100, 0);
    run_op("R3 word sub", 5'b00110, 32'h8000_0010, 32'h0000_0100, 0);
  endtask

  task automatic t_unsigned();
    run_op("R4 ubyte add", 5'b10000, 32'hF0FF_0102, 32'h20FF_0304, 0);
    run_op("R4 uhalf sub", 5'b10101, 32'h0001_9000, 32'h0002_1000, 0);
  endtask

  task automatic t_halving();
    run_op("R5 sbyte hadd", 5'b01000, 32'h8080_7F7F, 32'h8001_7F81, 0);
    run_op("R5 uhalf hadd", 5'b11001, 32'hFFFF_0003, 32'hFFFF_0000, 0);
    run_op("R5 sword hsub", 5'b01110, 32'h8000_0000, 32'h7FFF_FFFF, 0);
  endtask

  task automatic t_lanes();
    run_op("R6 byte carry", 5'b10000, 32'h0000_00FF, 32'h0000_0001, 1);
    run_op("R6 ubyte hadd", 5'b11000, 32'h00FF_00FF, 32'h0001_00FF, 0);
    run_op("R6 uhalf hsub", 5'b11101, 32'h0000_0000, 32'h0000_0001, 0);
  endtask

  task automatic t_clear();
    run_op("R8 set all", 5'b00000, 32'h7F7F_7F7F, 32'h7F7F_7F7F, 0);
    run_op("R8 keep", 5'b00000, 32'h0101_0101, 32'h0101_0101, 0);
    run_op("R9 clr priority", 5'b00000, 32'h7F7F_7F7F, 32'h7F7F_7F7F, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_bytes();   idle_check();
    t_halves();
    t_word();    idle_check();
    t_unsigned();
    t_halving();
    t_lanes();   idle_check();
    t_clear();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule